// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

A single timer channel that counts a 32-bit register downward at a rate set by a selectable divider of the peripheral clock. When the count is zero and another divided tick arrives, the channel reloads the count from a constant register and raises a sticky underflow flag. If the interrupt enable bit is set, that flag drives a level interrupt. The flag stays high until software clears it.

Software reaches the channel through a word-addressed register port. Reads are combinational from the address. A write lands on the clock edge where the write strobe is high. An outer unit starts and stops the channel with a run input. An optional capture word exists only as plain storage. Whether it is present is set by a feature parameter, and a second parameter admits the external-clock settings of the control word.

Top module: `tmr_chan`

## Requirements
- R1: After reset, word 0 (reload) and word 1 (counter) read 0xFFFFFFFF, word 2 (control) reads 0, and irq_o is 0.
- R2: Word 0 is a read/write reload register. Word 1 reads the live count and takes writes. Word 3 is the capture word.
- R3: Control bits [2:0] set the tick divider. Codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 running cycles. Every control write restarts the divider phase at zero.
- R4: On a tick with the count at 0, the counter loads the reload value and the underflow flag (read at control bit 8) sets in that same clock edge. On any other tick the count drops by one.
- R5: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves it unchanged, so software can never set it. If an underflow and a clearing write fall on the same edge, the flag ends up set.
- R6: irq_o is 1 exactly when the underflow flag and control bit 5 (interrupt enable) are both 1.
- R7: The counter and the divider phase advance only while run_i is 1. Lowering run_i freezes both, and raising it again resumes from the frozen values.
- R8: A counter write on the same edge as a tick wins. The count takes the written value, and no decrement or underflow occurs.
- R9: Control bits [15:9] are ignored on write and read as 0. Bits [4:3] (clock edge select) are stored only when external clocking is enabled, and read 0 otherwise.
- R10: A control write whose prescale code is 5, or 6 or 7 without external clocking, leaves the stored prescale code unchanged. The rest of the write still applies. With external clocking, codes 6 and 7 are stored and produce no internal ticks.
- R11: With the capture feature, word 3 stores any written value and control bits [7:6] are stored. Without it, word 3 reads 0 and bits [7:6] read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Count enable from the outer start/stop unit |
| addr_i | input | 2 | Word select for reads and writes |
| wr_i | input | 1 | Write strobe, one word per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word at addr_i |
| irq_o | output | 1 | Level underflow interrupt |

## Verification
The assertions assume that wr_i, addr_i and wdata_i are steady around each rising edge, and that only one word is written per cycle. The counter and divider checks also assume that run_i changes only between edges. The stimulus drives every input on the falling edge and raises run_i for an exact number of rising edges, so the number of ticks follows from the divider alone. Reads are made with run_i low, so the value seen is the frozen state. The one run of the tick-against-write race is placed on the cycle whose edge is known to be a tick.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned CFG_W    = 8;
  localparam int unsigned FLAG_BIT = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } reg_sel_e;

  // Field positions are fixed by the control word layout.
  typedef struct packed {
    logic [1:0]        cap_cfg;  // [7:6]
    logic              uie;      // [5]
    logic [1:0]        edge_sel; // [4:3]
    logic [CODE_W-1:0] psc;      // [2:0]
  } ctrl_t;

  localparam logic [CODE_W-1:0] EXT_CODE_LO = 3'd6;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_chan_pkg::*;
#(
  parameter int unsigned NCODES = 5,
  parameter int unsigned PSC_W  = 2 * NCODES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int unsigned NSLOT = 2 ** CODE_W;

  logic [NSLOT-1:0][PSC_W-1:0] term;
  logic [NSLOT-1:0]            slot_ok;
  logic [PSC_W-1:0]            pc_q;
  logic                        code_ok;

  for (genvar g = 0; g < NSLOT; g++) begin : g_term
    if (g < NCODES) begin : g_used
      assign term[g]    = PSC_W'((1 << (2 * g + 2)) - 1);
      assign slot_ok[g] = 1'b1;
    end else begin : g_unused
      assign term[g]    = '0;
      assign slot_ok[g] = 1'b0;
    end
  end

  assign code_ok = slot_ok[code_i];
  assign tick_o  = run_i && code_ok && (pc_q == term[code_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (restart_i)         pc_q <= '0;
    else if (tick_o)            pc_q <= '0;
    else if (run_i && code_ok)  pc_q <= pc_q + PSC_W'(1);
  end

  p_pc_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_ok |-> pc_q <= term[code_i]);

  p_pc_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(pc_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign uf_o  = tick_i && !wr_i && (cnt_q == '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (uf_o)   cnt_q <= reload_i;
    else if (tick_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  p_reload_on_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && cnt_q == '0) |=> cnt_q == $past(reload_i));

  p_decrement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_wr_priority_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_chan_pkg::*;
#(
  parameter bit          HAS_CAPTURE = 1'b1,
  parameter bit          HAS_EXTCLK  = 1'b0,
  parameter int unsigned NCODES      = 5,
  parameter int unsigned CTRL_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              uf_i,
  output ctrl_t             ctrl_o,
  output logic              flag_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  flag_q;
  logic  psc_ok;

  always_comb begin
    ctrl_d = ctrl_t'(wdata_i[CFG_W-1:0]);
    psc_ok = (32'(ctrl_d.psc) < NCODES) || (HAS_EXTCLK && ctrl_d.psc >= EXT_CODE_LO);
    if (!psc_ok)      ctrl_d.psc      = ctrl_q.psc;
    if (!HAS_EXTCLK)  ctrl_d.edge_sel = '0;
    if (!HAS_CAPTURE) ctrl_d.cap_cfg  = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_d;
  end

  // Hardware set wins over a same-cycle software clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            flag_q <= 1'b0;
    else if (uf_i)                          flag_q <= 1'b1;
    else if (wr_i && !wdata_i[FLAG_BIT])    flag_q <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;

  p_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> flag_q);

  p_no_sw_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !uf_i) |=> !flag_q);

  p_flag_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[FLAG_BIT] && !uf_i) |=> !flag_q);

  p_psc_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_EXTCLK |-> 32'(ctrl_q.psc) < NCODES);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CTRL_W      = 16,
  parameter int unsigned NCODES      = 5,
  parameter bit          HAS_CAPTURE = 1'b1,
  parameter bit          HAS_EXTCLK  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] reload_q, cnt, capt;
  logic              wr_reload, wr_count, wr_ctrl, wr_capt;
  logic              tick, uf, flag;
  ctrl_t             ctrl;

  assign wr_reload = wr_i && (addr_i == REG_RELOAD);
  assign wr_count  = wr_i && (addr_i == REG_COUNT);
  assign wr_ctrl   = wr_i && (addr_i == REG_CTRL);
  assign wr_capt   = wr_i && (addr_i == REG_CAPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reload_q <= '1;
    else if (wr_reload) reload_q <= wdata_i;
  end

  if (HAS_CAPTURE) begin : g_capt
    logic [DATA_W-1:0] capt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      capt_q <= '0;
      else if (wr_capt) capt_q <= wdata_i;
    end
    assign capt = capt_q;
  end else begin : g_no_capt
    assign capt = '0;
  end

  tmr_prescaler #(.NCODES(NCODES)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .restart_i (wr_ctrl),
    .code_i    (ctrl.psc),
    .tick_o    (tick)
  );

  tmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .wr_i     (wr_count),
    .wdata_i  (wdata_i),
    .reload_i (reload_q),
    .cnt_o    (cnt),
    .uf_o     (uf)
  );

  tmr_ctrl #(
    .HAS_CAPTURE (HAS_CAPTURE),
    .HAS_EXTCLK  (HAS_EXTCLK),
    .NCODES      (NCODES),
    .CTRL_W      (CTRL_W)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ctrl),
    .wdata_i (wdata_i[CTRL_W-1:0]),
    .uf_i    (uf),
    .ctrl_o  (ctrl),
    .flag_o  (flag)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_RELOAD: rdata_o = reload_q;
      REG_COUNT:  rdata_o = cnt;
      REG_CTRL: begin
        rdata_o[CFG_W-1:0] = ctrl;
        rdata_o[FLAG_BIT]  = flag;
      end
      REG_CAPT:   rdata_o = capt;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = flag & ctrl.uie;

  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_CTRL) |-> rdata_o[DATA_W-1:FLAG_BIT+1] == '0);

  p_irq_needs_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdata_o[FLAG_BIT] || addr_i != REG_CTRL));
endmodule

// File: tb/tmr_chan_tb_top.sv
`timescale 1ns/1ps
module tmr_chan_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  always #4 clk_i = ~clk_i;

  tmr_chan dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .addr_i(addr_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       q[$];
  item_t       it;
  logic        chk = 1'b0;
  logic [31:0] act;
  int          n_vec = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  // Monitor: pops one expectation per strobed cycle.
  always @(posedge clk_i) begin
    #1;
    if (chk && q.size() > 0) begin
      it  = q.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : rdata_o;
      n_vec++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic push(input bit is_irq, input logic [1:0] a,
                      input logic [31:0] e, input string tag);
    item_t x;
    x.is_irq = is_irq; x.exp = e; x.tag = tag;
    @(negedge clk_i);
    addr_i = a;
    q.push_back(x);
    chk = 1'b1;
    @(negedge clk_i);
    chk = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    push(1'b0, a, e, tag);
  endtask

  task automatic irq_is(input logic e, input string tag);
    push(1'b1, 2'd0, {31'b0, e}, tag);
  endtask

  task automatic run_for(input int n);
    @(negedge clk_i);
    run_i = 1'b1;
    repeat (n) @(negedge clk_i);
    run_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    rd(2'd0, 32'hFFFF_FFFF, "R1 reload");
    rd(2'd1, 32'hFFFF_FFFF, "R1 count");
    rd(2'd2, 32'h0, "R1 ctrl");
    irq_is(1'b0, "R1 irq");

    // R2 / R4: underflow reloads and sets flag
    wr(2'd0, 32'd5);
    rd(2'd0, 32'd5, "R2 reload rw");
    wr(2'd1, 32'd2);
    rd(2'd1, 32'd2, "R2 count rw");
    wr(2'd2, 32'h0);
    run_for(12);
    rd(2'd1, 32'd5, "R4 reload after zero");
    rd(2'd2, 32'h100, "R4 flag set");
    irq_is(1'b0, "R6 masked");

    // R5 / R6 flag handling
    wr(2'd2, 32'h120);
    rd(2'd2, 32'h120, "R5 write 1 keeps flag");
    irq_is(1'b1, "R6 irq high");
    wr(2'd2, 32'h020);
    rd(2'd2, 32'h020, "R5 clear");
    irq_is(1'b0, "R6 irq low");
    wr(2'd2, 32'h100);
    rd(2'd2, 32'h000, "R5 no sw set");

    // R3 divider codes
    wr(2'd2, 32'h1); wr(2'd1, 32'd100); run_for(40);
    rd(2'd1, 32'd98, "R3 div16");
    wr(2'd2, 32'h2); wr(2'd1, 32'd100); run_for(130);
    rd(2'd1, 32'd98, "R3 div64");
    wr(2'd2, 32'h3); wr(2'd1, 32'd100); run_for(520);
    rd(2'd1, 32'd98, "R3 div256");
    wr(2'd2, 32'h4); wr(2'd1, 32'd100); run_for(2100);
    rd(2'd1, 32'd98, "R3 div1024");

    // R7 freeze and resume
    wr(2'd2, 32'h0); wr(2'd1, 32'd50);
    run_for(6);
    rd(2'd1, 32'd49, "R7 frozen");
    run_for(6);
    rd(2'd1, 32'd47, "R7 resumed phase");

    // R8 write beats tick
    wr(2'd2, 32'h0); wr(2'd1, 32'd10);
    @(negedge clk_i) run_i = 1'b1;
    repeat (3) @(negedge clk_i);
    addr_i = 2'd1; wdata_i = 32'd77; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; run_i = 1'b0;
    rd(2'd1, 32'd77, "R8 write priority");
    rd(2'd2, 32'h0, "R8 no underflow");

    // R9 reserved and edge bits
    wr(2'd2, 32'hFE38);
    rd(2'd2, 32'h020, "R9 reserved ignored");

    // R10 illegal prescale codes
    wr(2'd2, 32'h5);
    rd(2'd2, 32'h0, "R10 code5 kept old");
    wr(2'd2, 32'h7);
    rd(2'd2, 32'h0, "R10 code7 kept old");
    wr(2'd1, 32'd20); run_for(8);
    rd(2'd1, 32'd18, "R10 still div4");

    // R11 capture storage
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, 32'h1234_5678, "R11 capture word");
    wr(2'd2, 32'h080);
    rd(2'd2, 32'h080, "R11 capture cfg");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule